// File: doc/BRIEF.md
# Fault-Only-First Segmented Load Sequencer

This block steps through a unit-stride, segmented vector load in which only the first segment is allowed to raise an exception. Once `start` is accepted it captures the base address, the element width, the register-group multiplier, the field count and the current vector length. It then issues one memory request per field of every segment. Segments are walked in ascending order and fields in ascending order inside each segment. The element size is also the stride, so the accesses form a single contiguous run of bytes.

Each accepted request gets exactly one response, and responses come back in issue order. A faulting response in segment 0 ends the operation with a trap. A faulting response in any later segment is swallowed. In that case the block stops issuing and drains the requests still in flight. It then reports a shortened vector length equal to the index of the faulting segment. When no fault occurs, `done` is raised with no trap and no length update. Returned data is handled elsewhere.

Top module: `ffl_seq_top`

## Requirements
- R1: Access number k (k = segment*nf + field) is requested at address `base_addr + k*E`. E is the element size in bytes: 1, 2, 4 or 8 for `eew_sel` 0, 1, 2 or 3.
- R2: Requests are issued segment-major, with fields in ascending order inside each segment. Each request carries its segment, its field, and the destination register group `field * M`, where M is 1, 2, 4 or 8 for `emul_sel` 0 to 3. The field count is `nf_m1 + 1`.
- R3: With no fault and vl > 0, exactly vl*nf requests are issued. `done` pulses for one cycle, one cycle after the last response. `trap` and `new_vl_valid` stay low.
- R4: A fault on any access of segment 0 raises `trap` in the same cycle as `done`, and `new_vl_valid` stays low.
- R5: The first fault on an access of segment i > 0 raises `new_vl_valid` together with `done`, with `new_vl = i` and no trap.
- R6: Once a fault response is taken, no further request is presented. The fault flags of the remaining outstanding responses are ignored. Completion is reported once all of them have returned.
- R7: A start with `vl_in = 0` issues no request and pulses `done` in the following cycle, without trap or length update.
- R8: `busy` is high from the accepted start until completion. A `start` pulse while busy is ignored.
- R9: No more than MAX_OUT requests are outstanding at any time. A presented request holds its payload until accepted, unless a fault response ends issuing.
- R10: After reset, `busy`, `req_valid`, `done`, `trap` and `new_vl_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| base_addr | input | ADDR_W | Byte address of access 0 |
| eew_sel | input | 2 | Element size select, bytes = 1 << eew_sel |
| emul_sel | input | 2 | Register group size select, size = 1 << emul_sel |
| nf_m1 | input | NF_W | Number of fields minus one |
| vl_in | input | VL_W | Current vector length (segment count) |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | Memory request presented |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Request byte address |
| req_seg | output | VL_W | Segment index of the request |
| req_field | output | NF_W | Field index of the request |
| req_vreg | output | NF_W+3 | Register-group offset of the destination |
| rsp_valid | input | 1 | Response for the oldest outstanding request |
| rsp_fault | input | 1 | That response carries an exception |
| done | output | 1 | Completion pulse |
| trap | output | 1 | Exception in segment 0 (with done) |
| new_vl_valid | output | 1 | Shortened vector length reported (with done) |
| new_vl | output | VL_W | Shortened vector length value |

## Verification
Several properties are checked on every cycle: the credit bound, a waiting request holding its payload, the end of issuing once a fault is taken, and the mutual exclusion and `done` pairing of `trap` and the length update. Only the bench scenarios can show that addresses follow the contiguous segment order for each element size, that register groups scale with the multiplier, and that the reported length equals the faulting segment. The same applies to later fault flags being discarded during the drain and to an empty or repeated start having no effect.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } ffl_state_e;

   // element size in bytes as a shift amount
   function automatic logic [3:0] elem_bytes(input logic [1:0] sel);
      return 4'd1 << sel;
   endfunction

endpackage

// File: rtl/ffl_walker.sv
// Segment/field position counter; used once for issue and once for responses.
module ffl_walker #(
   parameter int VL_W = 8,
   parameter int NF_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            adv,
   input  logic [NF_W-1:0] nf_m1,
   input  logic [VL_W-1:0] vl_m1,
   output logic [VL_W-1:0] seg,
   output logic [NF_W-1:0] fld,
   output logic            last,
   output logic            ended
);

   logic fld_wrap;

   assign fld_wrap = (fld == nf_m1);
   assign last     = fld_wrap && (seg == vl_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg   <= '0;
         fld   <= '0;
         ended <= 1'b0;
      end else if (clr) begin
         seg   <= '0;
         fld   <= '0;
         ended <= 1'b0;
      end else if (adv && !ended) begin
         if (fld_wrap) begin
            fld <= '0;
            if (seg == vl_m1) ended <= 1'b1;
            else              seg   <= seg + 1'b1;
         end else begin
            fld <= fld + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ffl_addr.sv
// Running byte address: the stride equals the element size, so one adder suffices.
module ffl_addr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   input  logic [1:0]        eew_sel,
   output logic [ADDR_W-1:0] addr
);
   import ffl_pkg::*;

   logic [ADDR_W-1:0] step;

   assign step = ADDR_W'(elem_bytes(eew_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (load)  addr <= base;
      else if (adv)   addr <= addr + step;
   end

endmodule

// File: rtl/ffl_credit.sv
// Outstanding-request tracker; a single flag when only one request may fly.
module ffl_credit #(
   parameter int MAX_OUT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic full,
   output logic will_empty
);
   localparam int CNT_W = $clog2(MAX_OUT + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (MAX_OUT == 1) begin : g_flag
         assign cnt_nxt = inc ? 1'b1 : (dec ? 1'b0 : cnt);
      end else begin : g_count
         assign cnt_nxt = cnt + CNT_W'(inc) - CNT_W'(dec);
      end
   endgenerate

   assign full       = (cnt == CNT_W'(MAX_OUT));
   assign will_empty = (cnt_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   a_r9_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAX_OUT));

   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |-> (cnt != '0));

endmodule

// File: rtl/ffl_seq_top.sv
module ffl_seq_top #(
   parameter int ADDR_W  = 32,
   parameter int VL_W    = 8,
   parameter int NF_W    = 3,
   parameter int MAX_OUT = 4,
   localparam int VREG_W = NF_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [1:0]        eew_sel,
   input  logic [1:0]        emul_sel,
   input  logic [NF_W-1:0]   nf_m1,
   input  logic [VL_W-1:0]   vl_in,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [VL_W-1:0]   req_seg,
   output logic [NF_W-1:0]   req_field,
   output logic [VREG_W-1:0] req_vreg,
   input  logic              rsp_valid,
   input  logic              rsp_fault,
   output logic              done,
   output logic              trap,
   output logic              new_vl_valid,
   output logic [VL_W-1:0]   new_vl
);
   import ffl_pkg::*;

   generate
      if (ADDR_W < 8)  begin : g_bad_addr $error("ADDR_W must be at least 8"); end
      if (VL_W < 1)    begin : g_bad_vl   $error("VL_W must be positive"); end
      if (NF_W < 1)    begin : g_bad_nf   $error("NF_W must be positive"); end
      if (MAX_OUT < 1) begin : g_bad_out  $error("MAX_OUT must be positive"); end
   endgenerate

   ffl_state_e        state;
   logic [1:0]        eew_q;
   logic [1:0]        emul_q;
   logic [NF_W-1:0]   nf_q;
   logic [VL_W-1:0]   vlm1_q;
   logic [VL_W-1:0]   fseg_q;

   logic              start_acc;
   logic              acc;
   logic              rsp_take;
   logic              cr_full;
   logic              cr_empty;
   logic              iss_last;
   logic              iss_ended;
   logic [VL_W-1:0]   rsp_seg;
   logic [NF_W-1:0]   rsp_fld;
   logic              rsp_last;
   logic              rsp_ended;
   logic              done_q;
   logic              trap_q;
   logic              nvl_q;
   logic [VL_W-1:0]   nvl_val_q;

   assign busy      = (state != ST_IDLE);
   assign start_acc = (state == ST_IDLE) && start;
   assign req_valid = (state == ST_RUN) && !iss_ended && !cr_full;
   assign acc       = req_valid && req_ready;
   assign rsp_take  = rsp_valid && busy;

   ffl_walker #(.VL_W(VL_W), .NF_W(NF_W)) u_iss (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_acc),
      .adv   (acc),
      .nf_m1 (nf_q),
      .vl_m1 (vlm1_q),
      .seg   (req_seg),
      .fld   (req_field),
      .last  (iss_last),
      .ended (iss_ended)
   );

   ffl_walker #(.VL_W(VL_W), .NF_W(NF_W)) u_rsp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_acc),
      .adv   (rsp_take && (state == ST_RUN)),
      .nf_m1 (nf_q),
      .vl_m1 (vlm1_q),
      .seg   (rsp_seg),
      .fld   (rsp_fld),
      .last  (rsp_last),
      .ended (rsp_ended)
   );

   ffl_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_acc),
      .base    (base_addr),
      .adv     (acc),
      .eew_sel (eew_q),
      .addr    (req_addr)
   );

   ffl_credit #(.MAX_OUT(MAX_OUT)) u_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc        (acc),
      .dec        (rsp_take),
      .full       (cr_full),
      .will_empty (cr_empty)
   );

   assign req_vreg = VREG_W'(req_field) << emul_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         eew_q     <= '0;
         emul_q    <= '0;
         nf_q      <= '0;
         vlm1_q    <= '0;
         fseg_q    <= '0;
         done_q    <= 1'b0;
         trap_q    <= 1'b0;
         nvl_q     <= 1'b0;
         nvl_val_q <= '0;
      end else begin
         done_q <= 1'b0;
         trap_q <= 1'b0;
         nvl_q  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  eew_q  <= eew_sel;
                  emul_q <= emul_sel;
                  nf_q   <= nf_m1;
                  vlm1_q <= vl_in - 1'b1;
                  if (vl_in == '0) done_q <= 1'b1;
                  else             state  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (rsp_take) begin
                  if (rsp_fault) begin
                     fseg_q <= rsp_seg;
                     if (cr_empty) begin
                        done_q    <= 1'b1;
                        trap_q    <= (rsp_seg == '0);
                        nvl_q     <= (rsp_seg != '0);
                        nvl_val_q <= rsp_seg;
                        state     <= ST_IDLE;
                     end else begin
                        state <= ST_DRAIN;
                     end
                  end else if (rsp_last) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end
               end
            end
            ST_DRAIN: begin
               if (rsp_take && cr_empty) begin
                  done_q    <= 1'b1;
                  trap_q    <= (fseg_q == '0);
                  nvl_q     <= (fseg_q != '0);
                  nvl_val_q <= fseg_q;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done         = done_q;
   assign trap         = trap_q;
   assign new_vl_valid = nvl_q;
   assign new_vl       = nvl_val_q;

   a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !(rsp_valid && rsp_fault))
         |=> (req_valid && $stable(req_addr) && $stable(req_seg) && $stable(req_field)));

   a_r6_stop_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_valid && rsp_fault) |=> !req_valid);

   a_r4_trap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (done && !new_vl_valid));

   a_r5_newvl_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      new_vl_valid |-> (done && !trap && (new_vl != '0)));

   a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/tb_ffl_seq_top.sv
module tb_ffl_seq_top;

   localparam int CLK_P = 10;

   typedef struct packed {
      logic [31:0] base;
      logic [7:0]  vl;
      logic [2:0]  nfm1;
      logic [1:0]  eew;
      logic [1:0]  emul;
      logic [11:0] fidx;   // 12'hFFF: no fault
      logic [1:0]  rdy;    // 0 always, 1 alternate, 2 every third cycle
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 8'd4, 3'd0, 2'd2, 2'd0, 12'hFFF, 2'd0},
      '{32'h0000_2000, 8'd3, 3'd2, 2'd2, 2'd1, 12'hFFF, 2'd1},
      '{32'h0000_3003, 8'd5, 3'd1, 2'd0, 2'd2, 12'hFFF, 2'd2},
      '{32'h0000_4000, 8'd6, 3'd1, 2'd3, 2'd0, 12'd7,   2'd0},
      '{32'h0000_5000, 8'd4, 3'd2, 2'd1, 2'd0, 12'd2,   2'd1},
      '{32'h0000_6000, 8'd5, 3'd0, 2'd2, 2'd0, 12'd0,   2'd0},
      '{32'h0000_7000, 8'd7, 3'd1, 2'd2, 2'd3, 12'd13,  2'd2},
      '{32'h0000_8000, 8'd8, 3'd7, 2'd0, 2'd0, 12'd8,   2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [1:0]  eew_sel = '0;
   logic [1:0]  emul_sel = '0;
   logic [2:0]  nf_m1 = '0;
   logic [7:0]  vl_in = '0;
   logic        req_ready = 1'b0;
   logic        rsp_valid = 1'b0;
   logic        rsp_fault = 1'b0;
   logic        busy, req_valid, done, trap, new_vl_valid;
   logic [31:0] req_addr;
   logic [7:0]  req_seg, new_vl;
   logic [2:0]  req_field;
   logic [5:0]  req_vreg;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   ffl_seq_top #(.ADDR_W(32), .VL_W(8), .NF_W(3), .MAX_OUT(4)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .eew_sel(eew_sel), .emul_sel(emul_sel), .nf_m1(nf_m1), .vl_in(vl_in),
      .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_seg(req_seg), .req_field(req_field),
      .req_vreg(req_vreg), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .done(done), .trap(trap), .new_vl_valid(new_vl_valid), .new_vl(new_vl)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] b, input int vl, input int nfm1,
                         input int ew, input int em, input int fidx,
                         input int rdy, input bit poke);
      int nf = nfm1 + 1;
      int total = vl * nf;
      int eb = 1 << ew;
      int issued = 0;
      int head = 0;
      int tail = 0;
      int cyc = 0;
      int pend [0:511];
      bit fault_sent = 0;
      bit seen_done = 0;
      bit addr_bad = 0;
      bit late_req = 0;
      longint bad_act = 0;
      longint bad_exp = 0;
      bit got_trap = 0;
      bit got_nvl = 0;
      int got_vl = 0;
      bit fault_hit;
      int fseg;

      @(negedge clk);
      base_addr = b; vl_in = 8'(vl); nf_m1 = 3'(nfm1);
      eew_sel = 2'(ew); emul_sel = 2'(em); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (cyc < 3000) begin
         bit f_before;
         if (done) begin
            seen_done = 1; got_trap = trap; got_nvl = new_vl_valid; got_vl = new_vl;
            break;
         end
         f_before = fault_sent;
         if (head < tail) begin
            rsp_valid = 1'b1;
            rsp_fault = (fidx >= 0) && (pend[head] >= fidx);
            if (rsp_fault) fault_sent = 1;
            head++;
         end else begin
            rsp_valid = 1'b0;
            rsp_fault = 1'b0;
         end
         req_ready = (rdy == 0) ? 1'b1 : (rdy == 1) ? cyc[0] : ((cyc % 3) == 0);
         if (poke && cyc == 2) begin
            // R8: design is mid-operation; a second start must be ignored
            chk(busy == 1'b1, "R8", "busy during operation", busy, 1);
            start = 1'b1; base_addr = 32'hDEAD_0000; vl_in = 8'd1;
         end else begin
            start = 1'b0;
         end
         if (req_valid && req_ready) begin
            longint ea = longint'(b) + longint'(issued) * eb;
            int es = issued / nf;
            int ef = issued % nf;
            if (f_before) late_req = 1;
            if (!addr_bad && (req_addr != 32'(ea) || req_seg != 8'(es) ||
                              req_field != 3'(ef) || req_vreg != 6'(ef << em))) begin
               addr_bad = 1; bad_act = req_addr; bad_exp = ea;
            end
            pend[tail] = issued;
            tail++;
            issued++;
         end
         cyc++;
         @(negedge clk);
      end
      rsp_valid = 1'b0; rsp_fault = 1'b0; req_ready = 1'b0; start = 1'b0;

      fault_hit = (fidx >= 0) && (fidx < total);
      fseg = fault_hit ? fidx / nf : 0;
      chk(seen_done, "R3", "done seen", seen_done, 1);
      chk(got_trap == (fault_hit && fseg == 0), "R4", "trap", got_trap, fault_hit && fseg == 0);
      chk(got_nvl == (fault_hit && fseg != 0), "R5", "new_vl_valid", got_nvl, fault_hit && fseg != 0);
      if (fault_hit && fseg != 0)
         chk(got_vl == fseg, "R5", "new_vl", got_vl, fseg);
      if (!fault_hit) begin
         chk(issued == total, "R3", "request count", issued, total);
      end else begin
         chk(issued >= fidx + 1 && issued <= total, "R6", "request count", issued, fidx + 1);
         chk(!late_req, "R6", "request after fault", late_req, 0);
      end
      chk(!addr_bad, "R1", "address/position (R2)", bad_act, bad_exp);
      @(negedge clk);
      chk(done == 1'b0, "R3", "done single pulse", done, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(busy == 1'b0, "R10", "busy", busy, 0);
      chk(req_valid == 1'b0, "R10", "req_valid", req_valid, 0);
      chk(done == 1'b0, "R10", "done", done, 0);
      chk(trap == 1'b0, "R10", "trap", trap, 0);
      chk(new_vl_valid == 1'b0, "R10", "new_vl_valid", new_vl_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].base, int'(VECS[i].vl), int'(VECS[i].nfm1),
                int'(VECS[i].eew), int'(VECS[i].emul),
                (VECS[i].fidx == 12'hFFF) ? -1 : int'(VECS[i].fidx),
                int'(VECS[i].rdy), 1'b0);
      end

      // R7: empty vector length
      @(negedge clk);
      base_addr = 32'h100; vl_in = 8'd0; nf_m1 = 3'd2; eew_sel = 2'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R7", "done after empty start", done, 1);
      chk(req_valid == 1'b0, "R7", "no request", req_valid, 0);
      chk(trap == 1'b0 && new_vl_valid == 1'b0, "R7", "no trap/update",
          trap | new_vl_valid, 0);
      @(negedge clk);
      chk(busy == 1'b0 && req_valid == 1'b0, "R7", "stays idle", busy | req_valid, 0);

      // R8: start while busy ignored
      run_op(32'h0000_9000, 4, 0, 2, 0, -1, 0, 1'b1);
      // R8: ignored start leaves no second operation behind
      chk(busy == 1'b0 && req_valid == 1'b0, "R8", "no extra operation",
          busy | req_valid, 0);

      // R4/R5 boundaries: fault in last access of segment 0, and in the last segment
      run_op(32'h0000_A000, 3, 3, 2, 1, 3, 1, 1'b0);
      run_op(32'h0000_B000, 2, 0, 3, 0, 1, 0, 1'b0);
      // R9: slow acceptance with a long run, fault never hit
      run_op(32'h0000_C000, 20, 1, 1, 0, 100, 2, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule